// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer that software controls through a small register window. A prescaler divides the reference clock by a programmable amount to make a slow tick. A tick counter compares its value with a programmed timeout. With the standard divider setting and a 24 MHz reference, each tick is one millisecond. Software restarts the count by writing to a dedicated restart address. If software stops doing so, the counter reaches the timeout and the block fires a fixed-length reset pulse. The pulse goes out on a main-domain reset output, an always-on-domain reset output, or both, as selected. The block also sets a sticky expired flag that can drive a level interrupt.

The control word holds five things. It carries the divider value in its low bits. It has three bits that must all be set before counting proceeds: an enable, a clock gate and a divider gate. It has separate reset selects for the two domains and an interrupt enable. It also has a self-clearing bit that fires the reset pulse at once. Every register clears on reset, so the block starts disabled. The asynchronous reset input is released through a two-stage synchronizer.

Top module: `wdt_top`

## Requirements
- R1: After reset all registers read zero and `rst_main_o`, `rst_ao_o` and `irq_o` are low.
- R2: Ticks occur once every (divider + 1) clocks, where the divider is control bits [17:0]. Counting happens only while control bits 18 (enable), 24 (clock gate) and 25 (divider gate) are all 1. While any of them is 0 the prescaler is cleared and the tick count holds.
- R3: When the tick count equals the timeout register (address 1) while counting is allowed, the block expires once. The count then holds until a restart. A timeout of 0 expires at once.
- R4: A write to address 2 with any data clears the prescaler and the tick count and re-arms expiry. A restart in the same cycle as a would-be expiry wins.
- R5: Status (address 3) shows the tick count in bits [15:0] and the expired flag in bit 31. The flag is set by expiry and stays set. Writing 1 to bit 31 clears it, and writing 0 there leaves it. If a set and a clear fall in the same cycle, the set wins.
- R6: Expiry starts a pulse of exactly 16 clocks. The pulse appears on `rst_main_o` if control bit 21 is 1 and on `rst_ao_o` if control bit 22 is 1.
- R7: Writing control with bit 26 set starts the same 16-clock pulse in the next cycle, whatever the enable and timeout. Bit 26 is not stored and reads as 0.
- R8: `irq_o` is high exactly while the expired flag is 1 and control bit 23 is 1.
- R9: Address 0 reads back the control bits that are implemented (bits [18:0] and bits [25:21]), with all other bits 0. Address 1 reads the timeout, and address 2 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 2 | Word address: 0 control, 1 timeout, 2 restart, 3 status |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| rst_main_o | output | 1 | Main-domain reset pulse |
| rst_ao_o | output | 1 | Always-on-domain reset pulse |
| irq_o | output | 1 | Expiry interrupt, level high |

## Verification
The assertions are checked on every cycle. They cover four local rules: the prescaler stays clear while counting is blocked, a restart clears the count, the count freezes after expiry, and the pulse counter loads and then counts down by one each cycle. They also check that the expired flag is sticky and cleared by a write of 1. Other behaviour depends on whole scenarios, and only the bench shows it. That includes the tick period for a given divider value and expiry at exactly the timeout. It also includes the 16-clock pulse width, the routing of the pulse to each domain, and the effect of periodic restarts in preventing expiry. The force bit, its read-back of 0, and the read-back of control with unimplemented bits masked are likewise checked by the bench. The bench also compares its own model with all outputs on every clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    ADDR_CTRL    = 2'd0,
    ADDR_TIMEOUT = 2'd1,
    ADDR_KICK    = 2'd2,
    ADDR_STATUS  = 2'd3
  } wdt_addr_e;

  // Control-word bit positions (software encodes against these).
  localparam int BIT_EN      = 18;
  localparam int BIT_MAIN_EN = 21;
  localparam int BIT_AO_EN   = 22;
  localparam int BIT_IRQ_EN  = 23;
  localparam int BIT_CLK_EN  = 24;
  localparam int BIT_DIV_EN  = 25;
  localparam int BIT_FORCE   = 26;
  localparam int BIT_EXPIRED = 31;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int DIV_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] pre_q, pre_d;
  logic             wrap;

  assign wrap   = (pre_q == div_i);
  assign tick_o = run_i & ~clr_i & wrap;

  always_comb begin
    pre_d = pre_q;
    if (clr_i || !run_i) pre_d = '0;
    else if (wrap)       pre_d = '0;
    else                 pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_d;
  end

  AST_PRE_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (pre_q == '0)); // R2
endmodule

// File: rtl/wdt_tickcnt.sv
module wdt_tickcnt #(
  parameter int TCNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic [TCNT_W-1:0] timeout_i,
  output logic [TCNT_W-1:0] count_o,
  output logic              expire_o
);
  logic [TCNT_W-1:0] cnt_q, cnt_d;
  logic              trip_q, trip_d;
  logic              at_limit;

  assign at_limit = (cnt_q == timeout_i);
  assign expire_o = run_i & ~clr_i & ~trip_q & at_limit;
  assign count_o  = cnt_q;

  always_comb begin
    cnt_d  = cnt_q;
    trip_d = trip_q;
    if (clr_i) begin
      cnt_d  = '0;
      trip_d = 1'b0;
    end else begin
      if (tick_i && !trip_q && !at_limit) cnt_d = cnt_q + 1'b1;
      if (expire_o) trip_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      trip_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      trip_q <= trip_d;
    end
  end

  AST_KICK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0)); // R4
  AST_HOLD_AFTER_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_q && !clr_i) |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic active_o
);
  localparam int CW = $clog2(PULSE_LEN + 1);
  localparam logic [CW-1:0] LEN = CW'(PULSE_LEN);

  logic [CW-1:0] cnt_q, cnt_d;

  assign active_o = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (fire_i)        cnt_d = LEN;
    else if (active_o) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  AST_PULSE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> (cnt_q == LEN)); // R6
  AST_PULSE_SHRINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !fire_i) |=> (cnt_q == CW'($past(cnt_q) - 1'b1))); // R6
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int DIV_W  = 18,
  parameter int TCNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [TCNT_W-1:0] count_i,
  input  logic              expire_i,
  output logic [31:0]       rdata_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [TCNT_W-1:0] timeout_o,
  output logic              run_o,
  output logic              kick_o,
  output logic              force_o,
  output logic              main_en_o,
  output logic              ao_en_o,
  output logic              irq_o
);
  localparam logic [31:0] DIV_MASK  = (32'd1 << DIV_W) - 32'd1;
  localparam logic [31:0] CTRL_MASK = DIV_MASK | (32'd1 << BIT_EN)
    | (32'd1 << BIT_MAIN_EN) | (32'd1 << BIT_AO_EN) | (32'd1 << BIT_IRQ_EN)
    | (32'd1 << BIT_CLK_EN) | (32'd1 << BIT_DIV_EN);

  logic [31:0]       ctrl_q, ctrl_d;
  logic [TCNT_W-1:0] tmo_q, tmo_d;
  logic              exp_q, exp_d;
  logic              wr_ctrl, wr_tmo, wr_stat;

  assign wr_ctrl = we_i && (addr_i == ADDR_CTRL);
  assign wr_tmo  = we_i && (addr_i == ADDR_TIMEOUT);
  assign wr_stat = we_i && (addr_i == ADDR_STATUS);
  assign kick_o  = we_i && (addr_i == ADDR_KICK);
  assign force_o = wr_ctrl && wdata_i[BIT_FORCE];

  assign div_o     = ctrl_q[DIV_W-1:0];
  assign timeout_o = tmo_q;
  assign run_o     = ctrl_q[BIT_EN] & ctrl_q[BIT_CLK_EN] & ctrl_q[BIT_DIV_EN];
  assign main_en_o = ctrl_q[BIT_MAIN_EN];
  assign ao_en_o   = ctrl_q[BIT_AO_EN];
  assign irq_o     = exp_q & ctrl_q[BIT_IRQ_EN];

  always_comb begin
    ctrl_d = ctrl_q;
    tmo_d  = tmo_q;
    exp_d  = exp_q;
    if (wr_ctrl) ctrl_d = wdata_i & CTRL_MASK;
    if (wr_tmo)  tmo_d  = wdata_i[TCNT_W-1:0];
    if (expire_i)                          exp_d = 1'b1;
    else if (wr_stat && wdata_i[BIT_EXPIRED]) exp_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      tmo_q  <= '0;
      exp_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      tmo_q  <= tmo_d;
      exp_q  <= exp_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL:    rdata_o = ctrl_q;
      ADDR_TIMEOUT: rdata_o[TCNT_W-1:0] = tmo_q;
      ADDR_KICK:    rdata_o = '0;
      ADDR_STATUS: begin
        rdata_o[TCNT_W-1:0]  = count_i;
        rdata_o[BIT_EXPIRED] = exp_q;
      end
      default:      rdata_o = '0;
    endcase
  end

  AST_EXPIRED_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> exp_q); // R5
  AST_FLAG_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && wdata_i[BIT_EXPIRED] && !expire_i) |=> !exp_q); // R5
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exp_q && !(wr_stat && wdata_i[BIT_EXPIRED])) |=> exp_q); // R5
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int DIV_W     = 18,
  parameter int TCNT_W    = 16,
  parameter int PULSE_LEN = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        rst_main_o,
  output logic        rst_ao_o,
  output logic        irq_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_n;
  logic [DIV_W-1:0]  div;
  logic [TCNT_W-1:0] timeout, count;
  logic              run, kick, force_req, main_en, ao_en;
  logic              tick, expire, pulse_on;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  wdt_regs #(.DIV_W(DIV_W), .TCNT_W(TCNT_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_n), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .count_i(count), .expire_i(expire),
    .rdata_o(reg_rdata_o), .div_o(div), .timeout_o(timeout), .run_o(run),
    .kick_o(kick), .force_o(force_req), .main_en_o(main_en),
    .ao_en_o(ao_en), .irq_o(irq_o)
  );

  wdt_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_n), .run_i(run), .clr_i(kick),
    .div_i(div), .tick_o(tick)
  );

  wdt_tickcnt #(.TCNT_W(TCNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_n), .run_i(run), .clr_i(kick),
    .tick_i(tick), .timeout_i(timeout), .count_o(count), .expire_o(expire)
  );

  wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk_i(clk_i), .rst_ni(rst_n), .fire_i(expire | force_req),
    .active_o(pulse_on)
  );

  assign rst_main_o = pulse_on & main_en;
  assign rst_ao_o   = pulse_on & ao_en;

  AST_FORCE_FIRES: assert property (@(posedge clk_i) disable iff (!rst_n)
    force_req |=> pulse_on); // R7
endmodule

// File: tb/tb_wdt_top.sv
module tb_wdt_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_main, rst_ao, irq;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdt_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rst_main_o(rst_main),
    .rst_ao_o(rst_ao), .irq_o(irq)
  );

  localparam logic [31:0] MASK = 32'h03E7_FFFF;
  localparam logic [31:0] RUNB = (32'd1<<18)|(32'd1<<24)|(32'd1<<25);

  // Behavioural reference model
  logic [31:0] m_ctrl;
  int m_tmo, m_pre, m_cnt, m_pulse;
  bit m_trip, m_exp;

  task automatic model_reset();
    m_ctrl = '0; m_tmo = 0; m_pre = 0; m_cnt = 0; m_pulse = 0;
    m_trip = 0; m_exp = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_ni) model_reset();
    else begin
      bit run, kick, frc, evt, tick;
      int div;
      div  = int'(m_ctrl[17:0]);
      run  = m_ctrl[18] && m_ctrl[24] && m_ctrl[25];
      kick = we && addr == 2'd2;
      frc  = we && addr == 2'd0 && wdata[26];
      evt  = run && !kick && !m_trip && (m_cnt == m_tmo);
      tick = run && !kick && (m_pre == div);
      if (kick) begin m_cnt = 0; m_trip = 0; end
      else begin
        if (tick && !m_trip && m_cnt != m_tmo) m_cnt = (m_cnt + 1) % 65536;
        if (evt) m_trip = 1;
      end
      if (kick || !run || m_pre == div) m_pre = 0; else m_pre = m_pre + 1;
      if (evt) m_exp = 1;
      else if (we && addr == 2'd3 && wdata[31]) m_exp = 0;
      if (evt || frc) m_pulse = 16; else if (m_pulse > 0) m_pulse = m_pulse - 1;
      if (we && addr == 2'd0) m_ctrl = wdata & MASK;
      if (we && addr == 2'd1) m_tmo = int'(wdata[15:0]);
    end
  end

  function automatic logic [31:0] model_read(logic [1:0] a);
    case (a)
      2'd0: return m_ctrl;
      2'd1: return 32'(m_tmo);
      2'd2: return 32'd0;
      default: return {m_exp, 15'd0, 16'(m_cnt)};
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      check(rst_main == (m_pulse > 0 && m_ctrl[21]), "R6 rst_main", 32'(rst_main), 32'(m_pulse > 0 && m_ctrl[21]));
      check(rst_ao == (m_pulse > 0 && m_ctrl[22]), "R6 rst_ao", 32'(rst_ao), 32'(m_pulse > 0 && m_ctrl[22]));
      check(irq == (m_exp && m_ctrl[23]), "R8 irq", 32'(irq), 32'(m_exp && m_ctrl[23]));
      check(rdata == model_read(addr), "R9 rdata", rdata, model_read(addr));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic measure_pulse(input bit main_sel, output int width);
    int guard = 0;
    width = 0;
    @(negedge clk);
    while (!(main_sel ? rst_main : rst_ao) && guard < 200) begin guard++; @(negedge clk); end
    while ((main_sel ? rst_main : rst_ao) && width < 200) begin width++; @(negedge clk); end
  endtask

  logic [31:0] v, v2;
  int w;

  initial begin
    model_reset();
    idle(3);
    @(negedge clk); rst_ni = 1'b1;
    idle(4);

    // R1: reset state
    check(!rst_main && !rst_ao && !irq, "R1 outputs", {29'd0, rst_main, rst_ao, irq}, 32'd0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check(v == 32'd0, "R1 register", v, 32'd0);
    end

    // R3/R6/R8: expiry with divider 3, timeout 5, main reset + irq
    wr(2'd1, 32'd5);
    wr(2'd2, 32'hDEAD_BEEF);
    wr(2'd0, RUNB | (32'd1<<21) | (32'd1<<23) | 32'd3);
    measure_pulse(1'b1, w);
    check(w == 16, "R6 main pulse width", 32'(w), 32'd16);
    check(!rst_ao, "R6 ao stays low", 32'(rst_ao), 32'd0);
    idle(30);
    rd(2'd3, v);
    check(v == 32'h8000_0005, "R3 count held at timeout, R5 flag", v, 32'h8000_0005);
    check(irq, "R8 irq while expired", 32'(irq), 32'd1);

    // R5: writing 0 to bit 31 leaves flag, writing 1 clears it
    wr(2'd3, 32'h0000_FFFF);
    rd(2'd3, v);
    check(v[31], "R5 zero write keeps flag", v, 32'h8000_0005);
    wr(2'd3, 32'h8000_0000);
    rd(2'd3, v);
    check(v == 32'h0000_0005, "R5 W1C clears flag", v, 32'h0000_0005);
    check(!irq, "R8 irq drops with flag", 32'(irq), 32'd0);

    // R4: periodic restarts prevent expiry
    wr(2'd2, 32'd0);
    for (int k = 0; k < 10; k++) begin
      idle(8);
      wr(2'd2, 32'(k));
    end
    rd(2'd3, v);
    check(v[31] == 1'b0 && v[15:0] < 16'd5, "R4 kicks prevent expiry", v, 32'd0);

    // R2: clearing the enable holds the count
    idle(6);
    wr(2'd0, (32'd1<<24) | (32'd1<<25) | 32'd3);
    rd(2'd3, v);
    idle(30);
    rd(2'd3, v2);
    check(v2 == v, "R2 disable holds count", v2, v);

    // R2: divider gate clear blocks counting
    wr(2'd2, 32'd0);
    wr(2'd0, (32'd1<<18) | (32'd1<<24) | 32'd3);
    idle(30);
    rd(2'd3, v);
    check(v == 32'd0, "R2 gate blocks counting", v, 32'd0);

    // R2: tick period of divider+1 clocks, divider 9
    wr(2'd1, 32'd100);
    wr(2'd2, 32'd0);
    wr(2'd0, RUNB | 32'd9);
    idle(49);
    rd(2'd3, v);
    check(v == 32'd5, "R2 ten-clock tick period", v, 32'd5);

    // R7: force fires on the always-on output with the enable clear
    wr(2'd0, (32'd1<<26) | (32'd1<<22));
    measure_pulse(1'b0, w);
    check(w == 16, "R7 forced pulse width", 32'(w), 32'd16);
    rd(2'd0, v);
    check(v == (32'd1<<22), "R7 force bit reads zero", v, 32'd1<<22);

    // R3: timeout of 0 expires at once
    wr(2'd1, 32'd0);
    wr(2'd2, 32'd0);
    wr(2'd0, RUNB | (32'd1<<23));
    idle(3);
    rd(2'd3, v);
    check(v == 32'h8000_0000, "R3 zero timeout", v, 32'h8000_0000);

    // R9: register map read-back
    wr(2'd0, 32'hFBFF_FFFF);
    rd(2'd0, v);
    check(v == MASK, "R9 control mask", v, MASK);
    wr(2'd0, 32'd0);
    wr(2'd1, 32'h1234_ABCD);
    rd(2'd1, v);
    check(v == 32'h0000_ABCD, "R9 timeout read", v, 32'h0000_ABCD);
    rd(2'd2, v);
    check(v == 32'd0, "R9 restart reads zero", v, 32'd0);

    idle(4);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule